// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer that connects two unrelated clock domains. A producer pushes 9-bit words on the write clock and a consumer pulls them on the read clock. Each side has its own enable pins, and all enables are active low except the optional second write enable. The storage is an inferred two-port memory of `DEPTH` words, and `DEPTH` must be a power of two.

Each domain keeps a binary pointer that is one bit wider than the address. It sends the Gray-coded form of that pointer to the other domain through a two-flop synchroniser. Each side then computes its own flags from its next local pointer and the synchronised remote pointer:

- The read side produces `empty_n` and `almost_empty_n`.
- The write side produces `full_n` and `almost_full_n`.

A neighbouring offset-register block supplies two thresholds at run time: `ae_ofs` (n) for almost-empty and `af_ofs` (m) for almost-full. The read data sits in an output register. That register keeps the last word read while the buffer is empty.

The write side is a two-state machine:

- After any reset it is in `WST_CFG`. In that state it blocks writes and captures the level of `wr_en2` as the write mode: 1 means dual enable, 0 means single enable.
- On the next write-clock edge it takes the transition `CFG->RUN` and stays in `WST_RUN` until the next reset. No other transitions exist.

Top module: `pflag_dc_fifo`

## Requirements
- R1: In dual-enable mode, a rising `wr_clk` edge stores `wr_data` only when `wr_en1_n` is 0, `wr_en2` is 1 and `full_n` is 1. Any other combination stores nothing.
- R2: The mode is taken from `wr_en2` at the first `wr_clk` edge after reset is released. A value of 0 selects single-enable mode, in which `wr_en2` is ignored and `wr_en1_n` = 0 alone (with `full_n` = 1) stores a word.
- R3: A rising `rd_clk` edge reads a word only when `rd_en1_n` and `rd_en2_n` are both 0 and `empty_n` is 1. The word then appears on `rd_data` after that edge. If only one read enable is low, nothing is read.
- R4: `empty_n` and `almost_empty_n` change only at rising `rd_clk` edges. `full_n` and `almost_full_n` change only at rising `wr_clk` edges. Reset assertion is the only exception.
- R5: Once settled, `almost_empty_n` is 0 while the word count is at most n (`ae_ofs`) and 1 once the count is n+1 or more. A change of n takes effect at run time.
- R6: Once settled, `almost_full_n` is 0 while the count is at least DEPTH−m (`af_ofs`) and 1 otherwise.
- R7: `full_n` is 0 when DEPTH words are held. Writes attempted while full are dropped, and no stored word is overwritten.
- R8: While `rst_n` is 0:
  - `rd_data` is 0.
  - `empty_n` and `almost_empty_n` are 0.
  - `full_n` and `almost_full_n` are 1.
- R9: Read attempts while empty leave `rd_data` at the last word read.
- R10: Words leave in the order they were accepted, with the two clocks running at unrelated rates. After activity stops, all flags match the stored count within a few destination-clock cycles, and the held count never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en1_n | input | 1 | Primary write enable, active low |
| wr_en2 | input | 1 | Second write enable (active high); its level at the first edge after reset selects the mode |
| wr_data | input | WIDTH | Word to store |
| rd_en1_n | input | 1 | First read enable, active low |
| rd_en2_n | input | 1 | Second read enable, active low |
| rd_data | output | WIDTH | Output register holding the last word read |
| ae_ofs | input | AW | Almost-empty threshold n |
| af_ofs | input | AW | Almost-full threshold m |
| empty_n | output | 1 | Low when no word is held (read domain) |
| almost_empty_n | output | 1 | Low when n or fewer words are held (read domain) |
| full_n | output | 1 | Low when DEPTH words are held (write domain) |
| almost_full_n | output | 1 | Low when DEPTH−m or more words are held (write domain) |

## Verification
The bench looks at the threshold boundaries from both sides:

- It checks the counts n and n+1, including after n is changed at run time; an off-by-one comparison would show the almost-empty flag one word late.
- It checks DEPTH−m−1 and DEPTH−m; a similar off-by-one comparison would show the almost-full flag one word late.

It fills the buffer completely and then tries more writes. A full detector that fails to stop them would overwrite the oldest word, and the drained sequence would then show a mismatch. Reads with one enable low, reads while empty and writes missing the second enable expose gating that is too loose: words appear or vanish, or the held output changes. A design that captured the mode wrongly would drop the single-enable writes. A flag process clocked in the wrong domain would be caught by the edge-alignment monitor.

// File: rtl/pff_pkg.sv
package pff_pkg;

    typedef enum logic {
        WMODE_SINGLE = 1'b0,
        WMODE_DUAL   = 1'b1
    } wmode_e;

    typedef enum logic {
        WST_CFG = 1'b0,
        WST_RUN = 1'b1
    } wstate_e;

    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/pff_sync.sv
module pff_sync #(
    parameter int W      = 10,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pff_mem.sv
module pff_mem #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 512,
    parameter int AW    = 9
) (
    input  logic             wr_clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] ram [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) ram[waddr] <= wdata;
    end

    assign rdata = ram[raddr];
endmodule

// File: rtl/pff_wr_ctl.sv
module pff_wr_ctl
    import pff_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int AW    = 9,
    parameter int PW    = 10
) (
    input  logic          wr_clk,
    input  logic          rst_n,
    input  logic          en1_n,
    input  logic          en2,
    input  logic [PW-1:0] rgray_sync,
    input  logic [AW-1:0] af_ofs,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wbin,
    output logic [PW-1:0] wgray,
    output logic          full_n,
    output logic          almost_full_n
);
    wstate_e       state_q, state_d;
    wmode_e        mode_q;
    logic          wr_req;
    logic [PW-1:0] wbin_nxt, rbin_sync, fill_nxt, af_limit;

    // state register
    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) state_q <= WST_CFG;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        unique case (state_q)
            WST_CFG: state_d = WST_RUN;
            WST_RUN: state_d = WST_RUN;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        unique case (state_q)
            WST_CFG: wr_req = 1'b0;
            WST_RUN: wr_req = !en1_n && (mode_q == WMODE_SINGLE || en2);
        endcase
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n)                 mode_q <= WMODE_DUAL;
        else if (state_q == WST_CFG) mode_q <= wmode_e'(en2);
    end

    assign we        = wr_req && full_n;
    assign wbin_nxt  = wbin + PW'(we);
    assign rbin_sync = PW'(from_gray(32'(rgray_sync)));
    assign fill_nxt  = wbin_nxt - rbin_sync;
    assign af_limit  = PW'(DEPTH) - {1'b0, af_ofs};

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            wbin          <= '0;
            wgray         <= '0;
            full_n        <= 1'b1;
            almost_full_n <= 1'b1;
        end else begin
            wbin          <= wbin_nxt;
            wgray         <= PW'(to_gray(32'(wbin_nxt)));
            full_n        <= (fill_nxt != PW'(DEPTH));
            almost_full_n <= (fill_nxt < af_limit);
        end
    end

    assign waddr = wbin[AW-1:0];
endmodule

// File: rtl/pff_rd_ctl.sv
module pff_rd_ctl
    import pff_pkg::*;
#(
    parameter int WIDTH = 9,
    parameter int AW    = 9,
    parameter int PW    = 10
) (
    input  logic             rd_clk,
    input  logic             rst_n,
    input  logic             en1_n,
    input  logic             en2_n,
    input  logic [PW-1:0]    wgray_sync,
    input  logic [AW-1:0]    ae_ofs,
    input  logic [WIDTH-1:0] mem_q,
    output logic [AW-1:0]    raddr,
    output logic [PW-1:0]    rbin,
    output logic [PW-1:0]    rgray,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty_n,
    output logic             almost_empty_n
);
    logic          do_rd;
    logic [PW-1:0] rbin_nxt, wbin_sync, fill_nxt;

    assign do_rd     = !en1_n && !en2_n && empty_n;
    assign rbin_nxt  = rbin + PW'(do_rd);
    assign wbin_sync = PW'(from_gray(32'(wgray_sync)));
    assign fill_nxt  = wbin_sync - rbin_nxt;

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            rbin           <= '0;
            rgray          <= '0;
            rd_data        <= '0;
            empty_n        <= 1'b0;
            almost_empty_n <= 1'b0;
        end else begin
            rbin           <= rbin_nxt;
            rgray          <= PW'(to_gray(32'(rbin_nxt)));
            if (do_rd) rd_data <= mem_q;
            empty_n        <= (fill_nxt != '0);
            almost_empty_n <= (fill_nxt > {1'b0, ae_ofs});
        end
    end

    assign raddr = rbin[AW-1:0];
endmodule

// File: rtl/pflag_dc_fifo.sv
module pflag_dc_fifo #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             wr_clk,
    input  logic             rd_clk,
    input  logic             rst_n,
    input  logic             wr_en1_n,
    input  logic             wr_en2,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en1_n,
    input  logic             rd_en2_n,
    output logic [WIDTH-1:0] rd_data,
    input  logic [AW-1:0]    ae_ofs,
    input  logic [AW-1:0]    af_ofs,
    output logic             empty_n,
    output logic             almost_empty_n,
    output logic             full_n,
    output logic             almost_full_n
);
    localparam int PW = AW + 1;

    logic             we;
    logic [AW-1:0]    waddr, raddr;
    logic [PW-1:0]    wptr_bin, wptr_gray, rptr_bin, rptr_gray;
    logic [PW-1:0]    wgray_at_rd, rgray_at_wr;
    logic [WIDTH-1:0] mem_q;

    pff_sync #(.W(PW), .STAGES(2)) u_w2r (
        .clk(rd_clk), .rst_n(rst_n), .d(wptr_gray), .q(wgray_at_rd)
    );

    pff_sync #(.W(PW), .STAGES(2)) u_r2w (
        .clk(wr_clk), .rst_n(rst_n), .d(rptr_gray), .q(rgray_at_wr)
    );

    pff_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(mem_q)
    );

    pff_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
        .wr_clk(wr_clk), .rst_n(rst_n), .en1_n(wr_en1_n), .en2(wr_en2),
        .rgray_sync(rgray_at_wr), .af_ofs(af_ofs), .we(we), .waddr(waddr),
        .wbin(wptr_bin), .wgray(wptr_gray), .full_n(full_n),
        .almost_full_n(almost_full_n)
    );

    pff_rd_ctl #(.WIDTH(WIDTH), .AW(AW), .PW(PW)) u_rd (
        .rd_clk(rd_clk), .rst_n(rst_n), .en1_n(rd_en1_n), .en2_n(rd_en2_n),
        .wgray_sync(wgray_at_rd), .ae_ofs(ae_ofs), .mem_q(mem_q),
        .raddr(raddr), .rbin(rptr_bin), .rgray(rptr_gray), .rd_data(rd_data),
        .empty_n(empty_n), .almost_empty_n(almost_empty_n)
    );
endmodule

// File: rtl/pff_checker.sv
module pff_checker #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 512,
    parameter int PW    = 10
) (
    input logic             wr_clk,
    input logic             rd_clk,
    input logic             rst_n,
    input logic             full_n,
    input logic             almost_full_n,
    input logic             empty_n,
    input logic             almost_empty_n,
    input logic [WIDTH-1:0] rd_data,
    input logic [PW-1:0]    wptr_bin,
    input logic [PW-1:0]    rptr_bin
);
    logic [PW-1:0] occ;
    assign occ = wptr_bin - rptr_bin;

    // R7: full blocks the write pointer
    p_no_overflow_r7: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !full_n |=> $stable(wptr_bin));

    // R3: empty blocks the read pointer
    p_no_underflow_r3: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |=> $stable(rptr_bin));

    // R9: output register holds while empty
    p_hold_on_empty_r9: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |=> $stable(rd_data));

    // R6: full implies almost full
    p_full_in_af_r6: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !full_n |-> !almost_full_n);

    // R5: empty implies almost empty
    p_empty_in_ae_r5: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |-> !almost_empty_n);

    // R10: held count never above capacity
    p_bounded_fill_r10: assert property (@(posedge wr_clk) disable iff (!rst_n)
        occ <= PW'(DEPTH));
endmodule

bind pflag_dc_fifo pff_checker #(.WIDTH(WIDTH), .DEPTH(DEPTH), .PW(PW)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .full_n(full_n),
    .almost_full_n(almost_full_n), .empty_n(empty_n),
    .almost_empty_n(almost_empty_n), .rd_data(rd_data),
    .wptr_bin(wptr_bin), .rptr_bin(rptr_bin)
);

// File: tb/pflag_dc_fifo_tb_top.sv
module pflag_dc_fifo_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RD_PERIOD  = 14;
    localparam int WQ    = CLK_PERIOD / 4;
    localparam int RQ    = RD_PERIOD / 4;
    localparam int WIDTH = 9;
    localparam int DEPTH = 512;
    localparam int AW    = 9;

    logic             wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
    logic             wr_en1_n = 1'b1, wr_en2 = 1'b1;
    logic             rd_en1_n = 1'b1, rd_en2_n = 1'b1;
    logic [WIDTH-1:0] wr_data = '0;
    logic [WIDTH-1:0] rd_data;
    logic [AW-1:0]    ae_ofs = 7, af_ofs = 7;
    logic             empty_n, almost_empty_n, full_n, almost_full_n;

    int checks = 0, fails = 0, r4_bad = 0, n_cur = 7, m_cur = 7;
    bit mode_dual = 1'b1, rd_pend = 1'b0;
    logic [WIDTH-1:0] exp_q[$];
    logic [WIDTH-1:0] hold = '0, last_rd = '0;
    time t_rd = 0, t_wr = 0;

    pflag_dc_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dut_i (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
        .wr_en1_n(wr_en1_n), .wr_en2(wr_en2), .wr_data(wr_data),
        .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n), .rd_data(rd_data),
        .ae_ofs(ae_ofs), .af_ofs(af_ofs), .empty_n(empty_n),
        .almost_empty_n(almost_empty_n), .full_n(full_n),
        .almost_full_n(almost_full_n)
    );

    initial forever #(CLK_PERIOD/2) wr_clk = ~wr_clk;
    initial forever #(RD_PERIOD/2) rd_clk = ~rd_clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // R4: flag edges aligned to their own clock
    always @(posedge rd_clk) t_rd = $time;
    always @(posedge wr_clk) t_wr = $time;
    always @(empty_n, almost_empty_n) if (rst_n === 1'b1 && $time != t_rd) r4_bad++;
    always @(full_n, almost_full_n)   if (rst_n === 1'b1 && $time != t_wr) r4_bad++;

    // monitor: pops expected word on each read the design performs
    always @(negedge rd_clk) begin
        #(RQ);
        if (rd_pend) begin
            chk(rd_data == hold, "R10", "read data order", int'(rd_data), int'(hold));
            last_rd = rd_data;
        end
        rd_pend = rst_n && !rd_en1_n && !rd_en2_n && empty_n;
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3", "read while model empty", 1, 0);
                rd_pend = 1'b0;
            end else begin
                hold = exp_q.pop_front();
            end
        end
    end

    // driver: one write-clock cycle of stimulus
    task automatic wr_one(input bit e1n, input bit e2, input logic [WIDTH-1:0] d);
        @(negedge wr_clk);
        wr_en1_n = e1n; wr_en2 = e2; wr_data = d;
        #(WQ);
        if (!e1n && full_n && (!mode_dual || e2)) exp_q.push_back(d);
    endtask

    task automatic wr_idle();
        @(negedge wr_clk);
        wr_en1_n = 1'b1;
    endtask

    task automatic wr_burst(input int n, input int seed);
        for (int i = 0; i < n; i++) wr_one(1'b0, 1'b1, WIDTH'((seed + i * 37) & 'h1FF));
        wr_idle();
    endtask

    task automatic rd_drive(input int n, input bit e1n, input bit e2n);
        for (int i = 0; i < n; i++) begin
            @(negedge rd_clk);
            rd_en1_n = e1n; rd_en2_n = e2n;
        end
        @(negedge rd_clk);
        rd_en1_n = 1'b1; rd_en2_n = 1'b1;
    endtask

    task automatic check_flags(input string req);
        int cnt;
        repeat (8) @(negedge rd_clk);
        #(RQ + 1);
        cnt = exp_q.size();
        chk(empty_n == (cnt != 0), req, "empty_n", int'(empty_n), int'(cnt != 0));
        chk(almost_empty_n == (cnt > n_cur), req, "almost_empty_n",
            int'(almost_empty_n), int'(cnt > n_cur));
        chk(full_n == (cnt != DEPTH), req, "full_n", int'(full_n), int'(cnt != DEPTH));
        chk(almost_full_n == (cnt < DEPTH - m_cur), req, "almost_full_n",
            int'(almost_full_n), int'(cnt < DEPTH - m_cur));
    endtask

    task automatic do_reset(input bit dual);
        @(negedge wr_clk);
        rst_n = 1'b0; wr_en1_n = 1'b1; rd_en1_n = 1'b1; rd_en2_n = 1'b1;
        wr_en2 = dual; mode_dual = dual;
        exp_q.delete();
        repeat (3) @(negedge rd_clk);
        chk(rd_data == '0, "R8", "rd_data in reset", int'(rd_data), 0);
        chk(empty_n == 1'b0, "R8", "empty_n in reset", int'(empty_n), 0);
        chk(almost_empty_n == 1'b0, "R8", "almost_empty_n in reset", int'(almost_empty_n), 0);
        chk(full_n == 1'b1, "R8", "full_n in reset", int'(full_n), 1);
        chk(almost_full_n == 1'b1, "R8", "almost_full_n in reset", int'(almost_full_n), 1);
        @(negedge wr_clk);
        rst_n = 1'b1;
        repeat (3) @(negedge wr_clk);
        wr_en2 = 1'b1;
        repeat (2) @(negedge wr_clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        chk(1'b0, "R10", "watchdog expired", 0, 1);
        report();
        $finish;
    end

    initial begin
        do_reset(1'b1);

        // R1: gating in dual-enable mode
        wr_one(1'b0, 1'b0, 9'h055);
        wr_one(1'b1, 1'b1, 9'h0AA);
        wr_idle();
        check_flags("R1");

        // R5: almost-empty boundary at n and n+1
        wr_burst(7, 1);
        check_flags("R5");
        wr_burst(1, 100);
        check_flags("R5");
        ae_ofs = 3; n_cur = 3;
        check_flags("R5");

        // R3: one read enable alone reads nothing
        rd_drive(4, 1'b0, 1'b1);
        rd_drive(4, 1'b1, 1'b0);
        check_flags("R3");

        rd_drive(4, 1'b0, 1'b0);
        check_flags("R5");
        rd_drive(1, 1'b0, 1'b0);
        check_flags("R5");
        rd_drive(3, 1'b0, 1'b0);
        check_flags("R3");

        // R9: reads while empty keep the output
        rd_drive(6, 1'b0, 1'b0);
        repeat (3) @(negedge rd_clk);
        chk(rd_data == last_rd, "R9", "rd_data held while empty", int'(rd_data), int'(last_rd));

        // R6 / R7: almost-full boundary and full
        af_ofs = 5; m_cur = 5;
        wr_burst(DEPTH - 6, 3);
        check_flags("R6");
        wr_burst(1, 200);
        check_flags("R6");
        wr_burst(5, 50);
        check_flags("R7");
        wr_burst(3, 77);
        chk(exp_q.size() == DEPTH, "R7", "words accepted while full",
            exp_q.size(), DEPTH);
        rd_drive(DEPTH + 4, 1'b0, 1'b0);
        check_flags("R7");

        // R10: concurrent traffic at unrelated rates
        ae_ofs = 7; n_cur = 7; af_ofs = 7; m_cur = 7;
        fork
            begin
                for (int i = 0; i < 400; i++) begin
                    if (i % 5 == 3) wr_idle();
                    else wr_one(1'b0, 1'b1, WIDTH'((i * 91 + 17) & 'h1FF));
                end
                wr_idle();
            end
            begin
                for (int i = 0; i < 300; i++) begin
                    if (i % 7 == 2) rd_drive(1, 1'b1, 1'b1);
                    else rd_drive(1, 1'b0, 1'b0);
                end
            end
        join
        rd_drive(400, 1'b0, 1'b0);
        check_flags("R10");

        // R2: single-enable mode chosen at reset
        do_reset(1'b0);
        for (int i = 0; i < 5; i++) wr_one(1'b0, 1'b0, WIDTH'(300 + i));
        wr_idle();
        check_flags("R2");
        rd_drive(8, 1'b0, 1'b0);
        check_flags("R2");

        chk(r4_bad == 0, "R4", "flag changes off own clock edge", r4_bad, 0);
        report();
        $finish;
    end
endmodule